// File: doc/BRIEF.md
# Interrupt-to-DMA Request Steering Controller

This block sits between a set of peripheral interrupt sources, a single-outstanding DMA channel engine and the CPU interrupt controller. Each source owns a factor flag that its event sets, plus three control bits held in byte-wide registers: a DMA-request bit, a DMA-enable bit and a CPU interrupt-enable bit. A source whose DMA-request and DMA-enable bits are both 1 is steered. Its flag starts a DMA transfer on the channel mapped to that source, and its CPU interrupt is held back. Any other source with its flag set simply drives its CPU interrupt line.

Steered sources with a set flag are issued to the engine one at a time, lowest source index first. Each issue goes through a valid/ready request followed by a done pulse. With the done pulse the engine returns two status bits: whether the transfer count reached zero, and whether interrupt-on-completion was enabled in the descriptor. These two bits decide, each in its own way, whether the flag, the request bit and the enable bit are kept or cleared. The flag may stay set, so that an interrupt follows the last transfer. It may instead be cleared silently.

Request interface rules: `dma_req_valid` rises with `dma_req_ch` and stays high with the channel unchanged until a cycle in which `dma_req_ready` is high. A request is accepted at a clock edge where valid and ready are both high. The engine may hold ready low for any number of cycles. The block then waits, and no later source overtakes the stalled request. `dma_done` is honoured only after acceptance. A done pulse at any other time is ignored.

Top module: `irq_dma_steer`

## Requirements
- R1: After reset every flag and control bit is 0, so every register byte reads 0x00, `dma_req_valid` is 0 and `cpu_irq` is all zero.
- R2: `reg_addr[3:2]` selects a bank: 0 = factor flags, 1 = DMA-request bits, 2 = DMA-enable bits, 3 = CPU interrupt-enable bits. `reg_addr[1:0]` selects a byte, and bit b of byte k belongs to source 8k+b. Banks 1 to 3 take the written byte as written. In bank 0 writing 1 to a bit clears that flag and writing 0 leaves it alone. `reg_rdata` shows the addressed byte combinationally, with 0 for bits past the last source.
- R3: A factor event sets the source's flag at the next clock edge. A set wins over a software clear of that flag in the same cycle, and over a clear by a completion for that source in the same cycle.
- R4: A source that is not steered (request bit 0 or enable bit 0) drives `cpu_irq` high while its flag and its interrupt-enable bit are both 1, and it never produces a DMA request.
- R5: A steered source with its flag set keeps its `cpu_irq` low while it stays steered. It is issued on `dma_req_ch` = 32 + source index, and the channel stays stable while valid waits for ready.
- R6: The block issues a request the cycle after it sees a steered source with its flag set, or after it returns to idle. When several such sources are waiting, the lowest index is issued first. Only one transfer is outstanding at a time.
- R7: On completion with a nonzero count, the flag is cleared, the request and enable bits are kept, and no interrupt is raised.
- R8: On completion with the count at zero and interrupt-on-completion enabled, the flag stays set, the request bit is cleared and the enable bit is kept. The source's `cpu_irq` therefore rises if its interrupt-enable bit is 1.
- R9: On completion with the count at zero and interrupt-on-completion disabled, the flag is cleared, the enable bit is cleared, the request bit is kept, and no interrupt is raised.
- R10: Where a completion updates a bit, or holds the flag in the R8 case, that update takes priority over a register write to the same bit in the same cycle. The write's other bits still take effect.
- R11: `dma_done` has no effect on any flag, any control bit or the issue sequence unless a request has been accepted and not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| factor_evt | input | 26 | One-cycle event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bank (bits 3:2) and byte (bits 1:0) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data of the addressed byte |
| dma_req_valid | output | 1 | Channel request valid |
| dma_req_ready | input | 1 | Engine accepts the request |
| dma_req_ch | output | 6 | Requested channel number |
| dma_done | input | 1 | Transfer of the accepted request finished |
| dma_cnt_zero | input | 1 | Transfer count reached zero (with dma_done) |
| dma_int_en | input | 1 | Interrupt-on-completion enabled (with dma_done) |
| cpu_irq | output | 26 | Interrupt request per source |

## Verification
The collision that matters most is a factor event that lands in the same cycle as the clearing of that same flag. The clear can come from a write-1-to-clear or from a nonzero-count completion. The bench drives an event together with a flag write, and an event together with the done pulse for the source in flight. It then reads the flag back and, for a steered source, expects the same channel to be issued again. A second collision, between a completion and a write to the request bit it clears, is provoked the same way. It is judged by reading back the request byte. A behavioural model is also compared with the outputs on every clock.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } issue_st_e;

  typedef enum logic [1:0] {
    BK_FLAG = 2'd0,
    BK_DREQ = 2'd1,
    BK_DEN  = 2'd2,
    BK_IEN  = 2'd3
  } bank_e;

  typedef struct packed {
    logic cnt_zero;
    logic int_en;
  } done_stat_t;

endpackage

// File: rtl/steer_prio.sv
module steer_prio #(
  parameter int N     = 26,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = |cand;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand[k]) idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/steer_regs.sv
module steer_regs
  import steer_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int BYTE_W  = 2,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] factor_evt,
  input  logic               reg_wr,
  input  bank_e              bank,
  input  logic [BYTE_W-1:0]  byte_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               done_fire,
  input  logic [IDX_W-1:0]   done_idx,
  input  done_stat_t         stat,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] ie_o
);

  localparam int BYTES = 1 << BYTE_W;
  localparam int PADW  = BYTES * 8;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic f_q, r_q, e_q, i_q;
    logic wsel, hit, keep_int, zero_quiet;

    assign wsel       = reg_wr && (byte_sel == BYTE_W'(i / 8));
    assign hit        = done_fire && (done_idx == IDX_W'(i));
    assign keep_int   = stat.cnt_zero && stat.int_en;
    assign zero_quiet = stat.cnt_zero && !stat.int_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        r_q <= 1'b0;
        e_q <= 1'b0;
        i_q <= 1'b0;
      end else begin
        // flag: event > completion > software clear
        if (factor_evt[i]) begin
          f_q <= 1'b1;
        end else if (hit) begin
          if (!keep_int) f_q <= 1'b0;
        end else if (wsel && bank == BK_FLAG && reg_wdata[i % 8]) begin
          f_q <= 1'b0;
        end
        if (hit && keep_int) r_q <= 1'b0;
        else if (wsel && bank == BK_DREQ) r_q <= reg_wdata[i % 8];
        if (hit && zero_quiet) e_q <= 1'b0;
        else if (wsel && bank == BK_DEN) e_q <= reg_wdata[i % 8];
        if (wsel && bank == BK_IEN) i_q <= reg_wdata[i % 8];
      end
    end

    assign flag_o[i] = f_q;
    assign req_o[i]  = r_q;
    assign en_o[i]   = e_q;
    assign ie_o[i]   = i_q;
  end

  logic [PADW-1:0] bank_vec;
  always_comb begin
    case (bank)
      BK_FLAG: bank_vec = PADW'(flag_o);
      BK_DREQ: bank_vec = PADW'(req_o);
      BK_DEN:  bank_vec = PADW'(en_o);
      default: bank_vec = PADW'(ie_o);
    endcase
  end
  assign reg_rdata = bank_vec[{byte_sel, 3'b000} +: 8];

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    |factor_evt |=> ((flag_o & $past(factor_evt)) == $past(factor_evt)));

  a_r7_nonzero_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire && !stat.cnt_zero && !factor_evt[done_idx] |=> !flag_o[$past(done_idx)]);

  a_r8_last_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire && stat.cnt_zero && stat.int_en |=> !req_o[$past(done_idx)]);

  a_r9_quiet_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire && stat.cnt_zero && !stat.int_en |=> !en_o[$past(done_idx)]);

endmodule

// File: rtl/steer_issue.sv
module steer_issue
  import steer_pkg::*;
#(
  parameter int N       = 26,
  parameter int IDX_W   = 5,
  parameter int CH_W    = 6,
  parameter int BASE_CH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_any,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             ready,
  input  logic             done,
  output logic             valid,
  output logic [CH_W-1:0]  ch,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy,
  output logic             done_fire
);

  issue_st_e        st_q;
  logic [IDX_W-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (pick_any) begin
          cur_q <= pick_idx;
          st_q  <= ST_REQ;
        end
        ST_REQ:  if (ready) st_q <= ST_WAIT;
        ST_WAIT: if (done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign valid     = (st_q == ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign done_fire = (st_q == ST_WAIT) && done;
  assign cur_idx   = cur_q;
  assign ch        = CH_W'(BASE_CH) + CH_W'(cur_q);

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(ch));

  a_r5_channel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (int'(ch) >= BASE_CH) && (int'(ch) < BASE_CH + N));

endmodule

// File: rtl/irq_dma_steer.sv
module irq_dma_steer
  import steer_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int BASE_CH = 32,
  parameter int CH_W    = 6,
  parameter int ADDR_W  = 2 + $clog2((NUM_SRC + 7) / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] factor_evt,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               dma_req_valid,
  input  logic               dma_req_ready,
  output logic [CH_W-1:0]    dma_req_ch,
  input  logic               dma_done,
  input  logic               dma_cnt_zero,
  input  logic               dma_int_en,
  output logic [NUM_SRC-1:0] cpu_irq
);

  localparam int BYTE_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] flag, req, en, ie, steered, cand, inflight;
  logic               pick_any, busy, done_fire;
  logic [IDX_W-1:0]   pick_idx, cur_idx;
  done_stat_t         stat;
  bank_e              bank;

  assign bank = bank_e'(reg_addr[ADDR_W-1 -: 2]);
  assign stat = '{cnt_zero: dma_cnt_zero, int_en: dma_int_en};

  steer_regs #(.NUM_SRC(NUM_SRC), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .factor_evt(factor_evt),
    .reg_wr(reg_wr), .bank(bank), .byte_sel(reg_addr[BYTE_W-1:0]),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_fire(done_fire), .done_idx(cur_idx), .stat(stat),
    .flag_o(flag), .req_o(req), .en_o(en), .ie_o(ie)
  );

  assign steered = req & en;
  assign cand    = flag & steered;

  steer_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .cand(cand), .any(pick_any), .idx(pick_idx)
  );

  steer_issue #(.N(NUM_SRC), .IDX_W(IDX_W), .CH_W(CH_W), .BASE_CH(BASE_CH)) u_issue (
    .clk(clk), .rst_n(rst_n), .pick_any(pick_any), .pick_idx(pick_idx),
    .ready(dma_req_ready), .done(dma_done), .valid(dma_req_valid),
    .ch(dma_req_ch), .cur_idx(cur_idx), .busy(busy), .done_fire(done_fire)
  );

  always_comb begin
    inflight = '0;
    if (busy) inflight[cur_idx] = 1'b1;
  end

  assign cpu_irq = flag & ie & ~steered & ~inflight;

endmodule

// File: tb/sim_irq_dma_steer.sv
module sim_irq_dma_steer;
  localparam int NS = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] factor_evt = '0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          dma_req_valid;
  logic          dma_req_ready = 1'b0;
  logic [5:0]    dma_req_ch;
  logic          dma_done = 1'b0;
  logic          dma_cnt_zero = 1'b0;
  logic          dma_int_en = 1'b0;
  logic [NS-1:0] cpu_irq;

  always #2 clk = ~clk;

  irq_dma_steer u0 (
    .clk(clk), .rst_n(rst_n), .factor_evt(factor_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_ch(dma_req_ch), .dma_done(dma_done), .dma_cnt_zero(dma_cnt_zero),
    .dma_int_en(dma_int_en), .cpu_irq(cpu_irq)
  );

  int n_chk = 0, n_fail = 0, wd = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NS-1:0] m_flag = '0, m_req = '0, m_en = '0, m_ie = '0;
  int m_state = 0, m_cur = 0;

  always @(posedge clk) begin
    logic [NS-1:0] nf, nr, ne, ni;
    int ns, nc, pick;
    if (!rst_n) begin
      m_flag = '0; m_req = '0; m_en = '0; m_ie = '0; m_state = 0; m_cur = 0;
    end else begin
      nf = m_flag; nr = m_req; ne = m_en; ni = m_ie; ns = m_state; nc = m_cur;
      if (reg_wr) begin
        for (int b = 0; b < 8; b++) begin
          int s;
          s = int'(reg_addr[1:0]) * 8 + b;
          if (s < NS) begin
            case (reg_addr[3:2])
              2'd0: if (reg_wdata[b]) nf[s] = 1'b0;
              2'd1: nr[s] = reg_wdata[b];
              2'd2: ne[s] = reg_wdata[b];
              default: ni[s] = reg_wdata[b];
            endcase
          end
        end
      end
      if (m_state == 2 && dma_done) begin
        if (!dma_cnt_zero) nf[m_cur] = 1'b0;
        else if (dma_int_en) begin nr[m_cur] = 1'b0; nf[m_cur] = m_flag[m_cur]; end
        else begin nf[m_cur] = 1'b0; ne[m_cur] = 1'b0; end
        ns = 0;
      end
      for (int s = 0; s < NS; s++) if (factor_evt[s]) nf[s] = 1'b1;
      if (m_state == 0) begin
        pick = -1;
        for (int s = NS - 1; s >= 0; s--) if (m_flag[s] && m_req[s] && m_en[s]) pick = s;
        if (pick >= 0) begin ns = 1; nc = pick; end
      end else if (m_state == 1 && dma_req_ready) ns = 2;
      m_flag = nf; m_req = nr; m_en = ne; m_ie = ni; m_state = ns; m_cur = nc;
    end
  end

  function automatic logic [NS-1:0] exp_irq();
    logic [NS-1:0] busy_m;
    busy_m = '0;
    if (m_state != 0) busy_m[m_cur] = 1'b1;
    return m_flag & m_ie & ~(m_req & m_en) & ~busy_m;
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [31:0] v;
    case (reg_addr[3:2])
      2'd0: v = 32'(m_flag);
      2'd1: v = 32'(m_req);
      2'd2: v = 32'(m_en);
      default: v = 32'(m_ie);
    endcase
    return v[{reg_addr[1:0], 3'b000} +: 8];
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(dma_req_valid == (m_state == 1), "R6", "model valid", dma_req_valid, m_state == 1);
      if (m_state == 1)
        chk(dma_req_ch == 6'(32 + m_cur), "R5", "model channel", dma_req_ch, 32 + m_cur);
      chk(cpu_irq == exp_irq(), "R4", "model irq", cpu_irq, exp_irq());
      chk(reg_rdata == exp_rd(), "R2", "model readback", reg_rdata, exp_rd());
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog expired: actual %0d expected <20000", wd);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic evt(input logic [NS-1:0] m);
    factor_evt = m;
    cyc();
    factor_evt = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == e, tag, $sformatf("read addr %0h", a), reg_rdata, e);
    #1;
  endtask

  task automatic wait_valid();
    while (!dma_req_valid) cyc();
  endtask

  task automatic accept();
    dma_req_ready = 1'b1;
    cyc();
    dma_req_ready = 1'b0;
  endtask

  task automatic finish_xfer(input bit cz, input bit ie);
    dma_done = 1'b1; dma_cnt_zero = cz; dma_int_en = ie;
    cyc();
    dma_done = 1'b0; dma_cnt_zero = 1'b0; dma_int_en = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1");
    chk(dma_req_valid == 1'b0, "R1", "valid after reset", dma_req_valid, 0);
    chk(cpu_irq == '0, "R1", "irq after reset", cpu_irq, 0);

    // R2/R4: interrupt enables, plain interrupt source 3
    for (int b = 0; b < 4; b++) wr(4'(12 + b), 8'hFF);
    evt(NS'(1) << 3);
    chk(cpu_irq[3] == 1'b1, "R4", "plain source irq", cpu_irq[3], 1);
    cyc();
    chk(dma_req_valid == 1'b0, "R4", "no dma for plain source", dma_req_valid, 0);
    wr(4'h0, 8'h00);
    rd(4'h0, 8'h08, "R2");
    wr(4'h0, 8'h08);
    chk(cpu_irq[3] == 1'b0, "R2", "w1c clears flag", cpu_irq[3], 0);

    // R5/R6/R7: sources 2 and 5 steered, fired together
    wr(4'h4, 8'h24);
    wr(4'h8, 8'h24);
    evt((NS'(1) << 2) | (NS'(1) << 5));
    repeat (3) cyc();
    chk(dma_req_valid == 1'b1 && dma_req_ch == 6'd34, "R6", "lowest first", dma_req_ch, 34);
    chk(cpu_irq[2] == 1'b0 && cpu_irq[5] == 1'b0, "R5", "steered irq held",
        {cpu_irq[5], cpu_irq[2]}, 0);
    accept();
    finish_xfer(1'b0, 1'b0);
    rd(4'h0, 8'h20, "R7");
    rd(4'h4, 8'h24, "R7");
    rd(4'h8, 8'h24, "R7");
    wait_valid();
    chk(dma_req_ch == 6'd37, "R6", "second channel", dma_req_ch, 37);
    accept();
    finish_xfer(1'b1, 1'b1);
    chk(cpu_irq[5] == 1'b1, "R8", "irq after last transfer", cpu_irq[5], 1);
    rd(4'h0, 8'h20, "R8");
    rd(4'h4, 8'h04, "R8");
    rd(4'h8, 8'h24, "R8");

    // R9: source 20, quiet finish
    wr(4'h6, 8'h10);
    wr(4'hA, 8'h10);
    evt(NS'(1) << 20);
    wait_valid();
    chk(dma_req_ch == 6'd52, "R5", "channel of source 20", dma_req_ch, 52);
    accept();
    finish_xfer(1'b1, 1'b0);
    rd(4'h2, 8'h00, "R9");
    rd(4'hA, 8'h00, "R9");
    rd(4'h6, 8'h10, "R9");
    chk(cpu_irq[20] == 1'b0, "R9", "no irq on quiet finish", cpu_irq[20], 0);

    // R3: event beats software clear in the same cycle
    factor_evt = NS'(1) << 3; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h08;
    cyc();
    factor_evt = '0; reg_wr = 1'b0;
    rd(4'h0, 8'h28, "R3");
    wr(4'h0, 8'h28);

    // R10: completion beats write of the request bit
    evt(NS'(1) << 2);
    wait_valid();
    accept();
    dma_done = 1'b1; dma_cnt_zero = 1'b1; dma_int_en = 1'b1;
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h24;
    cyc();
    dma_done = 1'b0; dma_cnt_zero = 1'b0; dma_int_en = 1'b0; reg_wr = 1'b0;
    rd(4'h4, 8'h20, "R10");
    rd(4'h0, 8'h04, "R10");
    chk(cpu_irq[2] == 1'b1, "R10", "irq of held flag", cpu_irq[2], 1);

    // R3: event beats completion clear, source 5 reissued
    evt(NS'(1) << 5);
    wait_valid();
    chk(dma_req_ch == 6'd37, "R5", "source 5 channel", dma_req_ch, 37);
    accept();
    dma_done = 1'b1; factor_evt = NS'(1) << 5;
    cyc();
    dma_done = 1'b0; factor_evt = '0;
    rd(4'h0, 8'h24, "R3");
    wait_valid();
    chk(dma_req_ch == 6'd37, "R3", "reissue after collision", dma_req_ch, 37);
    accept();
    finish_xfer(1'b0, 1'b0);
    rd(4'h0, 8'h04, "R7");

    // R11: stray done while idle
    finish_xfer(1'b1, 1'b0);
    rd(4'h0, 8'h04, "R11");
    rd(4'h8, 8'h24, "R11");
    chk(dma_req_valid == 1'b0, "R11", "no issue from stray done", dma_req_valid, 0);

    repeat (4) cyc();
    summary();
    $finish;
  end

endmodule